// File: doc/BRIEF.md
# Nonvolatile Memory Write Guard

This block sits on the device side of a byte-writable nonvolatile memory and decides whether a bus write may start an internal programming operation. It samples the chip-enable, output-enable and write-enable strobes (all active low), the address and data buses, a supply-low flag and a programming-done signal on a device clock. When a write is allowed, it raises a one-cycle accept pulse that carries the latched address and data, and it sets a busy flag. The busy flag stays set until the programming timer reports completion.

Writes pass through a protection bit that keeps its value from one write to the next. The bit starts cleared, so plain writes are accepted. A three-write unlock prefix, followed by a data write, programs that byte and sets the bit. From then on, a plain write is dropped unless an unlock prefix comes just before it. A six-write clear sequence removes the protection. Command writes are used up by a sequence tracker and are never programmed. While programming is in progress, every read access inverts a status bit, so software can poll for completion without knowing the last address written.

Top module: `eeprom_wr_guard`

## Requirements
- R1: After synchronous active-low reset, `busy`, `wr_accept` and `tgl_q6` are 0 and protection is off, so the first plain write is accepted.
- R2: A write is the interval in which `ce_n` and `we_n` are both low and `oe_n` is high. It completes on the first clock edge where `ce_n` or `we_n` has risen while `oe_n` is still high. `wr_accept` then pulses high for exactly one cycle, starting one cycle after that edge. `wr_addr`/`wr_data` carry the address and data sampled on the last clock of the interval.
- R3: A write whose strobes never overlap is inhibited. So is a write in which `oe_n` is low, either during the strobe overlap or when it ends.
- R4: A write that completes while `vcc_low` is high is ignored completely, including by the sequence tracker.
- R5: While protection is off, any write that is not a command write is accepted.
- R6: The unlock prefix is three writes: (5555h, AAh), (2AAAh, 55h), (5555h, A0h). These writes are not accepted. The write that follows the prefix is accepted and turns protection on.
- R7: While protection is on, a non-command write that does not directly follow an unlock prefix is ignored.
- R8: The clear sequence is six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 20h). It turns protection off, and protection stays off for all later writes.
- R9: A write that does not match the next expected command step sends the tracker back to its start. If that write is (5555h, AAh), it counts as the first step of a new sequence.
- R10: `busy` rises together with `wr_accept` and falls one cycle after `prog_done` is sampled high. Writes that complete while `busy` is high are ignored and do not move the tracker.
- R11: While `busy` is high, each new read access (`ce_n` and `oe_n` both falling to low) inverts `tgl_q6` one cycle later. When `busy` is low, `tgl_q6` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data |
| vcc_low | input | 1 | Supply below the write threshold |
| prog_done | input | 1 | Programming timer finished |
| wr_accept | output | 1 | One-cycle pulse that starts programming |
| wr_addr | output | AW | Address of the accepted write |
| wr_data | output | DW | Data of the accepted write |
| busy | output | 1 | Programming in progress |
| tgl_q6 | output | 1 | Status bit that toggles on reads while busy |

## Verification
The protection bit and the sequence tracker cannot be seen from outside. If either holds a wrong value, the error appears only at the next non-command write: `wr_accept` either fires when it should stay low, or stays low when it should fire. The checks therefore follow every command pattern (complete, broken partway, or landing during busy) with a plain data write, and look at the accept pulse one cycle after the strobe ends. A wrong busy or toggle state shows up on `busy` or `tgl_q6` within one cycle of the `prog_done` pulse or read access that should have changed it.

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR_A  = 15'h5555,
  parameter logic [AW-1:0] KEY_ADDR_B  = 15'h2AAA,
  parameter logic [DW-1:0] KEY_DATA_A  = 8'hAA,
  parameter logic [DW-1:0] KEY_DATA_B  = 8'h55,
  parameter logic [DW-1:0] CODE_UNLOCK = 8'hA0,
  parameter logic [DW-1:0] CODE_CLEAR  = 8'h80,
  parameter logic [DW-1:0] CODE_CONFIRM = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          vcc_low,
  input  logic          prog_done,
  output logic          wr_accept,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          tgl_q6
);

  typedef enum logic [2:0] {
    T_IDLE, T_K1, T_K2, T_ARMED, T_C3, T_C4, T_C5
  } trk_t;

  trk_t          trk, trk_nx;
  logic          prot, prot_nx;
  logic          on_q, rd_q;
  logic [AW-1:0] cap_a;
  logic [DW-1:0] cap_d;
  logic          take, hit;

  wire strobe_on = !ce_n && !we_n && oe_n;
  wire rd_on     = !ce_n && !oe_n;
  wire wr_end    = on_q && (ce_n || we_n) && oe_n;
  wire wr_evt    = wr_end && !vcc_low && !busy;
  wire rd_start  = rd_on && !rd_q;

  wire is_k1  = (cap_a == KEY_ADDR_A) && (cap_d == KEY_DATA_A);
  wire is_k2  = (cap_a == KEY_ADDR_B) && (cap_d == KEY_DATA_B);
  wire is_unl = (cap_a == KEY_ADDR_A) && (cap_d == CODE_UNLOCK);
  wire is_clr = (cap_a == KEY_ADDR_A) && (cap_d == CODE_CLEAR);
  wire is_cfm = (cap_a == KEY_ADDR_A) && (cap_d == CODE_CONFIRM);

  always_comb begin
    trk_nx  = trk;
    prot_nx = prot;
    take    = 1'b0;
    hit     = 1'b0;
    if (wr_evt) begin
      if (trk == T_ARMED) begin
        take    = 1'b1;
        prot_nx = 1'b1;
        trk_nx  = T_IDLE;
        hit     = 1'b1;
      end else begin
        case (trk)
          T_K1: if (is_k2) begin trk_nx = T_K2; hit = 1'b1; end
          T_K2: begin
            if (is_unl) begin trk_nx = T_ARMED; hit = 1'b1; end
            else if (is_clr) begin trk_nx = T_C3; hit = 1'b1; end
          end
          T_C3: if (is_k1) begin trk_nx = T_C4; hit = 1'b1; end
          T_C4: if (is_k2) begin trk_nx = T_C5; hit = 1'b1; end
          T_C5: if (is_cfm) begin trk_nx = T_IDLE; prot_nx = 1'b0; hit = 1'b1; end
          default: ;
        endcase
        if (!hit) begin
          if (is_k1) trk_nx = T_K1;
          else begin
            trk_nx = T_IDLE;
            take   = !prot;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      rd_q  <= 1'b0;
      cap_a <= '0;
      cap_d <= '0;
    end else begin
      on_q <= strobe_on;
      rd_q <= rd_on;
      if (strobe_on) begin
        cap_a <= addr;
        cap_d <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk  <= T_IDLE;
      prot <= 1'b0;
    end else begin
      trk  <= trk_nx;
      prot <= prot_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_accept <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      busy      <= 1'b0;
      tgl_q6    <= 1'b0;
    end else begin
      wr_accept <= take;
      if (take) begin
        wr_addr <= cap_a;
        wr_data <= cap_d;
      end
      if (take) busy <= 1'b1;
      else if (prog_done) busy <= 1'b0;
      if (busy && rd_start) tgl_q6 <= !tgl_q6;
    end
  end

endmodule

module eeprom_wr_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic oe_n,
  input logic vcc_low,
  input logic prog_done,
  input logic wr_accept,
  input logic busy,
  input logic tgl_q6
);

  assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept);

  assert_oe_high_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> $past(oe_n));

  assert_no_write_low_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> !$past(vcc_low));

  assert_accept_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> (busy && !$past(busy)));

  assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_done) |=> !busy);

  assert_toggle_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(tgl_q6));

endmodule

bind eeprom_wr_guard eeprom_wr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .vcc_low(vcc_low),
  .prog_done(prog_done), .wr_accept(wr_accept), .busy(busy), .tgl_q6(tgl_q6)
);

// File: tb/sim_eeprom_wr_guard.sv
module sim_eeprom_wr_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic        vcc_low = 1'b0, prog_done = 1'b0;
  logic        wr_accept, busy, tgl_q6;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;

  always #2 clk = ~clk;

  eeprom_wr_guard u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .vcc_low(vcc_low), .prog_done(prog_done),
    .wr_accept(wr_accept), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .tgl_q6(tgl_q6)
  );

  int n_tests = 0, n_fail = 0;
  int acc_cnt = 0;
  logic [14:0] last_a;
  logic [7:0]  last_d;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int rseq[6] = '{1, 2, 4, 1, 2, 5};
  bit m_on, m_rd, m_busy, m_q6, m_prot, m_armed, m_acc, m_end;
  int m_ph, code;
  logic [14:0] m_a, m_wa;
  logic [7:0]  m_d, m_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_rd = 0; m_busy = 0; m_q6 = 0; m_prot = 0; m_armed = 0;
      m_acc = 0; m_ph = 0; m_a = 0; m_d = 0; m_wa = 0; m_wd = 0;
    end else begin
      m_end = m_on && (ce_n || we_n) && oe_n;
      m_acc = 0;
      if (m_end && !vcc_low && !m_busy) begin
        code = 0;
        if (m_a == 15'h5555 && m_d == 8'hAA) code = 1;
        if (m_a == 15'h2AAA && m_d == 8'h55) code = 2;
        if (m_a == 15'h5555 && m_d == 8'hA0) code = 3;
        if (m_a == 15'h5555 && m_d == 8'h80) code = 4;
        if (m_a == 15'h5555 && m_d == 8'h20) code = 5;
        if (m_armed) begin
          m_acc = 1; m_prot = 1; m_armed = 0; m_ph = 0;
        end else if (code != 0 && code == rseq[m_ph]) begin
          m_ph++;
          if (m_ph == 6) begin m_ph = 0; m_prot = 0; end
        end else if (m_ph == 2 && code == 3) begin
          m_armed = 1; m_ph = 0;
        end else if (code == 1) m_ph = 1;
        else begin
          m_ph = 0;
          if (!m_prot) m_acc = 1;
        end
      end
      if (m_busy && !ce_n && !oe_n && !m_rd) m_q6 = !m_q6;
      if (m_acc) begin m_busy = 1; m_wa = m_a; m_wd = m_d; end
      else if (prog_done) m_busy = 0;
      m_rd = !ce_n && !oe_n;
      m_on = !ce_n && !we_n && oe_n;
      if (m_on) begin m_a = addr; m_d = din; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(wr_accept === m_acc, "R2 accept vs model", wr_accept, m_acc);
      if (m_acc) begin
        check(wr_addr === m_wa, "R2 addr vs model", wr_addr, m_wa);
        check(wr_data === m_wd, "R2 data vs model", wr_data, m_wd);
      end
      check(busy === m_busy, "R10 busy vs model", busy, m_busy);
      check(tgl_q6 === m_q6, "R11 q6 vs model", tgl_q6, m_q6);
      if (wr_accept) begin acc_cnt++; last_a = wr_addr; last_d = wr_data; end
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit ce_first = 0);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    repeat (2) @(negedge clk);
    if (ce_first) ce_n = 1; else we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1; addr = '0; din = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk); ce_n = 0; oe_n = 0;
    repeat (2) @(negedge clk); ce_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic done();
    @(negedge clk); prog_done = 1;
    @(negedge clk); prog_done = 0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4ns * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n0;
    logic q0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0, "R1 busy after reset", busy, 0);
    check(wr_accept === 0, "R1 accept after reset", wr_accept, 0);
    check(tgl_q6 === 0, "R1 q6 after reset", tgl_q6, 0);

    n0 = acc_cnt; wr(15'h0100, 8'h3C);
    check(acc_cnt == n0 + 1, "R1 R5 first write accepted", acc_cnt - n0, 1);
    check(last_a == 15'h0100 && last_d == 8'h3C, "R2 latched addr/data", {last_a, last_d}, {15'h0100, 8'h3C});
    check(busy === 1, "R10 busy after accept", busy, 1);
    n0 = acc_cnt; wr(15'h0200, 8'h11);
    check(acc_cnt == n0, "R10 write while busy ignored", acc_cnt - n0, 0);
    q0 = tgl_q6; rd();
    check(tgl_q6 === !q0, "R11 toggle on read", tgl_q6, !q0);
    rd();
    check(tgl_q6 === q0, "R11 toggle back", tgl_q6, q0);
    done();
    check(busy === 0, "R10 done clears busy", busy, 0);
    q0 = tgl_q6; rd(); rd();
    check(tgl_q6 === q0, "R11 idle reads hold", tgl_q6, q0);

    n0 = acc_cnt;
    @(negedge clk); oe_n = 0; addr = 15'h0300; din = 8'h01; ce_n = 0; we_n = 0;
    repeat (2) @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
    @(negedge clk); we_n = 0; repeat (2) @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 0; repeat (2) @(negedge clk); ce_n = 1;
    repeat (2) @(negedge clk);
    check(acc_cnt == n0, "R3 inhibited strobes", acc_cnt - n0, 0);

    vcc_low = 1; wr(15'h0301, 8'h02); vcc_low = 0;
    check(acc_cnt == n0, "R4 low supply ignored", acc_cnt - n0, 0);

    wr(15'h0302, 8'hC3, 1);
    check(acc_cnt == n0 + 1 && last_a == 15'h0302 && last_d == 8'hC3, "R2 CE-first write", acc_cnt - n0, 1);
    done();

    n0 = acc_cnt; unlock();
    check(acc_cnt == n0, "R6 prefix not programmed", acc_cnt - n0, 0);
    wr(15'h0400, 8'h5A);
    check(acc_cnt == n0 + 1 && last_d == 8'h5A, "R6 unlocked write accepted", acc_cnt - n0, 1);
    done();
    n0 = acc_cnt; wr(15'h0401, 8'h66);
    check(acc_cnt == n0, "R7 plain write blocked", acc_cnt - n0, 0);

    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h0123, 8'h00); wr(15'h5555, 8'hA0);
    wr(15'h0402, 8'h77);
    check(acc_cnt == n0, "R9 broken prefix restarts", acc_cnt - n0, 0);
    wr(15'h5555, 8'hAA); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
    wr(15'h0403, 8'h88);
    check(acc_cnt == n0 + 1 && last_a == 15'h0403, "R9 repeated first step restarts", acc_cnt - n0, 1);
    done();

    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
    n0 = acc_cnt; wr(15'h0500, 8'h99);
    check(acc_cnt == n0 + 1 && last_d == 8'h99, "R8 clear sequence unprotects", acc_cnt - n0, 1);
    done();
    wr(15'h0501, 8'h9A);
    check(acc_cnt == n0 + 2, "R8 stays unprotected", acc_cnt - n0, 2);
    done();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule